// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that acts like a small 256-byte serial EEPROM. The bus controller and any other targets share the two wires with it. The block runs from the system clock and oversamples SCL and SDA through synchroniser stages. It never drives SDA high. Its only output is a pull-low enable, which the pad turns into an open-drain driver. Three strap inputs set the low bits of the target's bus address, so eight of these targets can share one bus.

The storage is an internal register file of 32 pages, with 8 bytes in each page. One address pointer is kept from one transaction to the next. Write transactions load the pointer and then store bytes. When a write runs past the end of a page, it wraps to the start of that same page. Read transactions stream bytes from the pointer for as long as the controller acknowledges each byte. The controller ends the stream by leaving the acknowledge bit high.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and the pointer is 0x00. Every location that has never been written reads back as 0xFF.
- R2: The first byte after a START or repeated START is the address byte. It is acknowledged only when bits 7..1 equal 1010 followed by `strap_i[2:0]`. When they differ, that byte and every later byte up to the next START are ignored: the target drives no acknowledge and stores no data.
- R3: The target acknowledges every byte it accepts by pulling SDA low during the ninth SCL clock. This covers the address byte, the data-address byte and each write data byte.
- R4: Bit 0 of the address byte selects the direction: 0 is write, 1 is read. In a write, the byte after the address byte loads the pointer. Each later byte is stored at the pointer, and the pointer then advances.
- R5: After each byte is stored, only pointer bits 2..0 advance. A write that passes the end of its 8-byte page wraps to the start of that page. Bits 7..3 of the pointer never change during a write.
- R6: A transaction that opens with a read-mode address byte returns the byte at the pointer left by the previous transaction. That is one past the last byte stored (wrapping within the page) or one past the last byte read.
- R7: A random read is a write-mode address byte, then a data-address byte, then a repeated START, then a read-mode address byte. The first byte returned is the one at the given data address.
- R8: In a read, a low level from the controller on the ninth clock makes the target send the byte at the next address. During reads the pointer wraps from 0xFF to 0x00 across the whole array.
- R9: A high level from the controller on the ninth clock of a read ends the read. The target releases SDA and drives nothing more until the next START.
- R10: A START or repeated START clears the bit count at any point, even in the middle of a byte, and returns the target to address decode.
- R11: `sda_pull_o` changes only while SCL is low. Read data leaves the target MSB first, with each bit presented after a falling edge of SCL.
- R12: A STOP returns the target to idle. Bytes clocked after a STOP and before the next START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired-AND of all drivers) |
| strap_i | input | 3 | Low three bits of this target's bus address |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release it |

## Verification
The assertions assume three things about the bus. Each SCL level lasts for more than the synchroniser delay plus one cycle. SDA changes only while SCL is low, except for START and STOP. The strap pins hold still during a transaction. The stimulus meets all three: its bus controller holds every SCL phase for ten system cycles or more, moves SDA only during the low phase, and changes the strap value only between transactions. Under these assumptions, a change of the pull enable while SCL is high points to a fault in the sequencer. An acknowledge after an address mismatch does the same.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam int          STRAP_W  = 3;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WORD,
        ST_ACK_WORD,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } state_e;

endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_sync_d, scl_sync_q;
    logic [SYNC_STAGES-1:0] sda_sync_d, sda_sync_q;
    logic                   scl_prev_q, sda_prev_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign scl_sync_d = {scl_sync_q[SYNC_STAGES-2:0], scl_i};
            assign sda_sync_d = {sda_sync_q[SYNC_STAGES-2:0], sda_i};
        end else begin : g_single
            assign scl_sync_d = scl_i;
            assign sda_sync_d = sda_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= scl_sync_d;
            sda_sync_q <= sda_sync_d;
            scl_prev_q <= scl_lvl_o;
            sda_prev_q <= sda_lvl_o;
        end
    end

    always_comb begin
        scl_lvl_o = scl_sync_q[SYNC_STAGES-1];
        sda_lvl_o = sda_sync_q[SYNC_STAGES-1];
        rise_o    = scl_lvl_o & ~scl_prev_q;
        fall_o    = ~scl_lvl_o & scl_prev_q;
        start_o   = scl_lvl_o & scl_prev_q & sda_prev_q & ~sda_lvl_o;
        stop_o    = scl_lvl_o & scl_prev_q & ~sda_prev_q & sda_lvl_o;
    end

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (wr_en_i) begin
            cell_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/eeprom_target_fsm.sv
module eeprom_target_fsm
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl_i,
    input  logic               sda_lvl_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               pull_o
);

    typedef struct packed {
        state_e             state;
        logic [CNT_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0]  shift;
        logic [BYTE_W-1:0]  tx;
        logic [ADDR_W-1:0]  ptr;
        logic               rw;
        logic               nack;
        logic               pull;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state: ST_IDLE, bit_cnt: '0, shift: '0, tx: '1,
        ptr: '0, rw: 1'b0, nack: 1'b0, pull: 1'b0
    };

    regs_t             r_d, r_q;
    logic [PAGE_W-1:0] page_lo_inc;
    logic              dev_match;
    state_e            state_q;

    assign state_q     = r_q.state;
    assign page_lo_inc = r_q.ptr[PAGE_W-1:0] + PAGE_W'(1);
    assign dev_match   = (r_q.shift[BYTE_W-1:1] == {DEV_CODE, strap_i});
    assign rd_addr_o   = r_q.ptr;
    assign wr_addr_o   = r_q.ptr;
    assign wr_data_o   = r_q.shift;
    assign pull_o      = r_q.pull;

    always_comb begin
        r_d     = r_q;
        wr_en_o = 1'b0;
        if (start_i) begin
            r_d.state   = ST_ADDR;
            r_d.bit_cnt = '0;
            r_d.pull    = 1'b0;
        end else if (stop_i) begin
            r_d.state   = ST_IDLE;
            r_d.bit_cnt = '0;
            r_d.pull    = 1'b0;
        end else if (rise_i) begin
            unique case (r_q.state)
                ST_ADDR, ST_WORD, ST_WDATA: begin
                    r_d.shift   = {r_q.shift[BYTE_W-2:0], sda_lvl_i};
                    r_d.bit_cnt = r_q.bit_cnt + CNT_W'(1);
                end
                ST_RACK: r_d.nack = sda_lvl_i;
                default: ;
            endcase
        end else if (fall_i) begin
            unique case (r_q.state)
                ST_ADDR: begin
                    if (r_q.bit_cnt == CNT_W'(BYTE_W)) begin
                        if (dev_match) begin
                            r_d.rw    = r_q.shift[0];
                            r_d.pull  = 1'b1;
                            r_d.state = ST_ACK_ADDR;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_WORD: begin
                    if (r_q.bit_cnt == CNT_W'(BYTE_W)) begin
                        r_d.ptr   = r_q.shift[ADDR_W-1:0];
                        r_d.pull  = 1'b1;
                        r_d.state = ST_ACK_WORD;
                    end
                end
                ST_WDATA: begin
                    if (r_q.bit_cnt == CNT_W'(BYTE_W)) begin
                        wr_en_o   = 1'b1;
                        r_d.ptr   = {r_q.ptr[ADDR_W-1:PAGE_W], page_lo_inc};
                        r_d.pull  = 1'b1;
                        r_d.state = ST_ACK_WDATA;
                    end
                end
                ST_ACK_ADDR: begin
                    r_d.bit_cnt = '0;
                    if (r_q.rw) begin
                        r_d.tx    = rd_data_i;
                        r_d.pull  = ~rd_data_i[BYTE_W-1];
                        r_d.ptr   = r_q.ptr + ADDR_W'(1);
                        r_d.state = ST_RDATA;
                    end else begin
                        r_d.pull  = 1'b0;
                        r_d.state = ST_WORD;
                    end
                end
                ST_ACK_WORD, ST_ACK_WDATA: begin
                    r_d.bit_cnt = '0;
                    r_d.pull    = 1'b0;
                    r_d.state   = ST_WDATA;
                end
                ST_RDATA: begin
                    if (r_q.bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        r_d.pull  = 1'b0;
                        r_d.state = ST_RACK;
                    end else begin
                        r_d.bit_cnt = r_q.bit_cnt + CNT_W'(1);
                        r_d.tx      = {r_q.tx[BYTE_W-2:0], 1'b1};
                        r_d.pull    = ~r_q.tx[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    r_d.bit_cnt = '0;
                    if (!r_q.nack) begin
                        r_d.tx    = rd_data_i;
                        r_d.pull  = ~rd_data_i[BYTE_W-1];
                        r_d.ptr   = r_q.ptr + ADDR_W'(1);
                        r_d.state = ST_RDATA;
                    end else begin
                        r_d.pull  = 1'b0;
                        r_d.state = ST_WAIT_STOP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    // R11
    pull_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl_i && $past(scl_lvl_i)) |-> $stable(pull_o));

    // R2
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_ADDR && $past(state_q) == ST_ADDR)
            |-> ($past(r_q.shift[BYTE_W-1:1]) == {DEV_CODE, $past(strap_i)}));

    // R10
    start_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_ADDR && r_q.bit_cnt == '0));

    // R12
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state_q == ST_IDLE));

    // R5
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> $stable(r_q.ptr[ADDR_W-1:PAGE_W]));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_STOP) |-> !pull_o);

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o
);

    logic              scl_lvl, sda_lvl, rise, fall, start, stop;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    eeprom_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .rise_o    (rise),
        .fall_o    (fall),
        .start_o   (start),
        .stop_o    (stop)
    );

    eeprom_target_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl_i (scl_lvl),
        .sda_lvl_i (sda_lvl),
        .rise_i    (rise),
        .fall_i    (fall),
        .start_i   (start),
        .stop_i    (stop),
        .strap_i   (strap_i),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .pull_o    (sda_pull_o)
    );

    eeprom_byte_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

endmodule

// File: tb/test_eeprom_i2c_target.sv
`timescale 1ns/1ps
module test_eeprom_i2c_target;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       sda_pull;
    wire        sda_line = sda_drv & ~sda_pull;

    int  n_checks = 0;
    int  n_err = 0;
    int  viol_high = 0;
    int  viol_own = 0;
    bit  done = 1'b0;
    bit  ctrl_owns = 1'b0;

    logic [7:0] mdl_mem [256];
    int         mdl_ptr = 0;
    logic [7:0] wbuf [16];

    always #4 clk = ~clk;

    eeprom_i2c_target i_eeprom_i2c_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull)
    );

    // per-clock monitor of the target's drive against the bus phase
    logic prev_scl = 1'b1, prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_drv && prev_scl && (sda_pull != prev_pull)) viol_high++;
            if (ctrl_owns && sda_pull) viol_own++;
        end
        prev_scl  <= scl_drv;
        prev_pull <= sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q();
        scl_drv = 1'b1; wait_q();
        sda_drv = 1'b0; wait_q();
        scl_drv = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q();
        scl_drv = 1'b1; wait_q();
        sda_drv = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        ctrl_owns = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_q();
            scl_drv = 1'b1; wait_q(); wait_q();
            scl_drv = 1'b0;
            if (i == 0) ctrl_owns = 1'b0;
            wait_q();
        end
        sda_drv = 1'b1; wait_q();
        scl_drv = 1'b1; wait_q();
        acked = !sda_line; wait_q();
        scl_drv = 1'b0; wait_q();
    endtask

    task automatic send_bits4(input logic [3:0] b);
        ctrl_owns = 1'b1;
        for (int i = 3; i >= 0; i--) begin
            sda_drv = b[i]; wait_q();
            scl_drv = 1'b1; wait_q(); wait_q();
            scl_drv = 1'b0; wait_q();
        end
        ctrl_owns = 1'b0;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_drv = 1'b1; wait_q();
            b[i] = sda_line; wait_q();
            scl_drv = 1'b0; wait_q();
        end
        sda_drv = last; wait_q();
        scl_drv = 1'b1; wait_q(); wait_q();
        scl_drv = 1'b0; wait_q();
        sda_drv = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1010, strap, rw};
    endfunction

    task automatic do_write(input int addr, input int n, input string tag);
        bit a;
        bus_start();
        send_byte(dev(1'b0), a);   chk(a, {tag, " R3 address ack"}, a, 1);
        send_byte(addr[7:0], a);   chk(a, {tag, " R3 data-address ack"}, a, 1);
        mdl_ptr = addr;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); chk(a, {tag, " R3 data ack"}, a, 1);
            mdl_mem[mdl_ptr] = wbuf[k];
            mdl_ptr = (mdl_ptr & 8'hF8) | ((mdl_ptr + 1) & 7);
        end
        bus_stop();
    endtask

    task automatic do_read(input bit random, input int addr, input int n, input string tag);
        bit a;
        logic [7:0] b;
        bus_start();
        if (random) begin
            send_byte(dev(1'b0), a); chk(a, {tag, " R7 write-mode address ack"}, a, 1);
            send_byte(addr[7:0], a); chk(a, {tag, " R7 data-address ack"}, a, 1);
            mdl_ptr = addr;
            bus_start();
        end
        send_byte(dev(1'b1), a);     chk(a, {tag, " R3 read-mode address ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            chk(b == mdl_mem[mdl_ptr], {tag, " R11 read data"}, b, mdl_mem[mdl_ptr]);
            mdl_ptr = (mdl_ptr + 1) & 8'hFF;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state and unwritten cells
        chk(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);
        do_read(1'b0, 0, 2, "R1 R6 current read from reset pointer");

        // R4: write two bytes, read them back
        wbuf[0] = 8'h5A; wbuf[1] = 8'h00;
        do_write(8'h10, 2, "R4 byte write");
        do_read(1'b1, 8'h10, 2, "R7 random read");

        // R9: nack ends read; further clocks see a released line
        do_read(1'b1, 8'h10, 1, "R9 single read");
        bus_start();
        send_byte(dev(1'b0), a); chk(a, "R9 setup ack", a, 1);
        send_byte(8'h10, a);     chk(a, "R9 setup ack", a, 1);
        bus_start();
        send_byte(dev(1'b1), a); chk(a, "R9 setup ack", a, 1);
        recv_byte(1'b1, b);      chk(b == 8'h5A, "R9 last byte", b, 8'h5A);
        recv_byte(1'b1, b);      chk(b == 8'hFF, "R9 released after nack", b, 8'hFF);
        bus_stop();
        mdl_ptr = 8'h11;
        do_read(1'b0, 0, 1, "R6 pointer after read");

        // R5: page write wraps inside the page
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hA1 + k[7:0];
        do_write(8'h1D, 6, "R5 page write");
        do_read(1'b0, 0, 1, "R6 pointer after write");
        do_read(1'b1, 8'h18, 8, "R5 R8 page contents");
        do_read(1'b1, 8'h20, 1, "R5 next page untouched");

        // R8: sequential read wraps across the array
        wbuf[0] = 8'h11; do_write(8'hFF, 1, "R4 last cell");
        wbuf[0] = 8'h22; do_write(8'h00, 1, "R4 first cell");
        do_read(1'b1, 8'hFE, 3, "R8 array wrap");

        // R2: mismatching address is ignored
        strap = 3'b101;
        repeat (Q) @(negedge clk);
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R2 mismatch not acked", a, 0);
        send_byte(8'h10, a); chk(!a, "R2 later byte ignored", a, 0);
        send_byte(8'h77, a); chk(!a, "R2 data ignored", a, 0);
        bus_stop();
        do_read(1'b1, 8'h10, 1, "R2 memory unchanged");

        // R10: repeated START in the middle of a byte
        bus_start();
        send_bits4(4'b1010);
        bus_start();
        send_byte(dev(1'b0), a); chk(a, "R10 address after restart", a, 1);
        send_byte(8'h30, a);     chk(a, "R10 data-address", a, 1);
        send_byte(8'h3C, a);     chk(a, "R10 data", a, 1);
        bus_stop();
        mdl_mem[8'h30] = 8'h3C; mdl_ptr = 8'h31;
        do_read(1'b1, 8'h30, 1, "R10 readback");

        // R12: no START after STOP means no response
        send_byte(dev(1'b0), a); chk(!a, "R12 byte without START", a, 0);
        bus_stop();
        do_read(1'b0, 0, 1, "R12 pointer kept");

        chk(viol_high == 0, "R11 drive changed with SCL high", viol_high, 0);
        chk(viol_own == 0, "R12 drive while controller owns SDA", viol_own, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule